// File: doc/BRIEF.md
# Response Gap Timeout Timer

This block times the quiet interval on the bus after the bus controller finishes sending a command. A one-cycle end-of-transmission pulse arms it. From then on it counts input clock cycles until the receiver reports a valid response sync, which stops the count with no error. If the count reaches the terminal value first, the block raises a one-cycle no-response pulse and sets a sticky no-response error.

Two control bits set the terminal value. One bit picks the gap: a short gap of 17 µs or a long gap of 131 µs. The other bit says whether the input clock runs at 24 MHz or 12 MHz, so the gap lasts the same time at either rate. The block captures both bits when it is armed.

A master reset clears the counter, the armed state and the error. So does the start of a new message. A host or sequencer reads the error, the pulse and the elapsed cycle count directly from the outputs.

Top module: `rsp_gap_timer`

## Requirements
- R1: After rst_n is released, armed, no_rsp_pulse and no_rsp_err are 0 and gap_count is 0.
- R2: With gap_long_sel=0 and clk_half_sel=0, arming with tx_end makes no_rsp_pulse rise exactly 408 clock edges after the arming edge, provided rx_sync_ok stays low.
- R3: With gap_long_sel=1 and clk_half_sel=0, the terminal count is 3144 edges.
- R4: With clk_half_sel=1, the terminal count is halved to 204 edges for the short gap and 1572 edges for the long gap. In general the terminal count is gap_us × clock_MHz.
- R5: When rx_sync_ok is high while the timer is armed, the timer disarms on that edge and no error is raised. This also holds in the last cycle before the terminal count.
- R6: no_rsp_pulse is high for exactly one cycle per timeout. no_rsp_err goes high at the same time and stays high until it is cleared.
- R7: mst_reset clears armed, gap_count and no_rsp_err on the next edge. It takes priority over every other input.
- R8: msg_start clears armed, gap_count and no_rsp_err in the same way as mst_reset.
- R9: The two select bits are captured on the arming edge. Changing them while the timer is armed has no effect on the terminal count.
- R10: A tx_end that arrives while the timer is armed restarts the count from zero.
- R11: rx_sync_ok has no effect while the timer is idle.
- R12: gap_count equals the number of edges since the arming edge while armed. It holds its value after a sync disarm, and it equals the terminal count after a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (24 or 12 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_reset | input | 1 | Synchronous master reset, clears timer and error |
| msg_start | input | 1 | New message start, clears timer and error |
| tx_end | input | 1 | End-of-transmission pulse, arms the timer |
| rx_sync_ok | input | 1 | Valid response sync detected by the receiver |
| gap_long_sel | input | 1 | 0 = 17 µs gap, 1 = 131 µs gap |
| clk_half_sel | input | 1 | 0 = 24 MHz input clock, 1 = 12 MHz input clock |
| armed | output | 1 | Timer is waiting for a response |
| no_rsp_pulse | output | 1 | One-cycle timeout pulse |
| no_rsp_err | output | 1 | Sticky no-response error |
| gap_count | output | CNT_W (12) | Edges counted since arming |

## Verification
Call the arming edge edge 0. The pulse and the sticky error first appear after edge L, where L is the terminal count. A sync or a clear takes effect on the edge that samples it. The bench drives every input on a falling edge and samples on the falling edge that follows the edge of interest. For every select combination it checks that there is no pulse after edge L−1 and that the pulse is present after edge L, and it checks the cycle after that as well. It computes L in the bench as gap_us × clock_MHz. Sync offsets include the first cycle and the last cycle before the terminal count, and gap_count is compared against the number of edges actually waited.

// File: rtl/gap_pkg.sv
package gap_pkg;

   // Terminal count for a gap given in microseconds at a clock given in kHz.
   function automatic int unsigned gap_cycles(input int unsigned gap_us,
                                              input int unsigned clk_khz);
      return (gap_us * clk_khz) / 1000;
   endfunction

   // Counter width able to hold the value n.
   function automatic int unsigned width_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((n >> w) != 0) w++;
      return w;
   endfunction

   typedef struct packed {
      logic long_gap;
      logic half_clk;
   } gap_sel_t;

endpackage

// File: rtl/gap_limit_sel.sv
module gap_limit_sel
   import gap_pkg::*;
#(
   parameter int unsigned SHORT_US    = 17,
   parameter int unsigned LONG_US     = 131,
   parameter int unsigned FAST_KHZ    = 24000,
   parameter int unsigned SLOW_DIV    = 2,
   parameter int unsigned LIMIT_STYLE = 0,
   parameter int unsigned CNT_W       = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             long_sel,
   input  logic             half_sel,
   output logic [CNT_W-1:0] limit
);

   localparam int unsigned SLOW_KHZ  = FAST_KHZ / SLOW_DIV;
   localparam int unsigned LIM_SF    = gap_cycles(SHORT_US, FAST_KHZ);
   localparam int unsigned LIM_LF    = gap_cycles(LONG_US,  FAST_KHZ);
   localparam int unsigned LIM_SS    = gap_cycles(SHORT_US, SLOW_KHZ);
   localparam int unsigned LIM_LS    = gap_cycles(LONG_US,  SLOW_KHZ);
   localparam int unsigned DIV_SHIFT = width_for(SLOW_DIV) - 1;

   if (SHORT_US == 0 || SHORT_US >= LONG_US) begin : g_bad_gap
      $error("gap_limit_sel: SHORT_US must be nonzero and below LONG_US");
   end
   if (SLOW_DIV < 1) begin : g_bad_div
      $error("gap_limit_sel: SLOW_DIV must be at least 1");
   end
   if (LIM_SS < 2) begin : g_bad_small
      $error("gap_limit_sel: slow short limit must be at least 2");
   end
   if (width_for(LIM_LF) > CNT_W) begin : g_bad_width
      $error("gap_limit_sel: CNT_W too narrow for the long gap");
   end
   if (LIMIT_STYLE == 1 && (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_shift
      $error("gap_limit_sel: shift style needs a power-of-two SLOW_DIV");
   end

   gap_sel_t sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (clr) begin
         sel_q <= '0;
      end else if (load) begin
         sel_q.long_gap <= long_sel;
         sel_q.half_clk <= half_sel;
      end
   end

   if (LIMIT_STYLE == 0) begin : g_table
      // Four precomputed constants, one selected by the captured bits.
      always_comb begin
         unique case ({sel_q.long_gap, sel_q.half_clk})
            2'b00:   limit = CNT_W'(LIM_SF);
            2'b01:   limit = CNT_W'(LIM_SS);
            2'b10:   limit = CNT_W'(LIM_LF);
            default: limit = CNT_W'(LIM_LS);
         endcase
      end
   end else begin : g_shift
      // Pick the fast-clock value, then shift right for the slow clock.
      logic [CNT_W-1:0] fast_lim;
      always_comb begin
         fast_lim = sel_q.long_gap ? CNT_W'(LIM_LF) : CNT_W'(LIM_SF);
         limit    = sel_q.half_clk ? (fast_lim >> DIV_SHIFT) : fast_lim;
      end
   end

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr) |=> $stable(sel_q)) else $error("AST_SEL_HELD"); // R9

endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
   parameter int unsigned CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             arm,
   input  logic             sync,
   input  logic [CNT_W-1:0] limit,
   output logic             armed,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_inc;
   logic             last_cyc;

   always_comb begin
      cnt_inc  = cnt + CNT_W'(1);
      last_cyc = (cnt_inc == limit);
      expire   = armed && !clr && !arm && !sync && last_cyc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (clr) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (arm) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (armed) begin
         if (sync) begin
            armed <= 1'b0;
         end else begin
            cnt <= cnt_inc;
            if (last_cyc) armed <= 1'b0;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt < limit)) else $error("AST_CNT_BOUND"); // R12
   AST_SYNC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sync && !arm && !clr) |=> (!armed && $stable(cnt))) else $error("AST_SYNC_DISARM"); // R5
   AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm && !clr) |=> (!armed && $stable(cnt))) else $error("AST_IDLE_SYNC"); // R11
   AST_REARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !clr) |=> (armed && cnt == '0)) else $error("AST_REARM_ZERO"); // R10

endmodule

// File: rtl/gap_err_flag.sv
module gap_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic expire,
   output logic pulse,
   output logic err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         err   <= 1'b0;
      end else begin
         pulse <= expire && !clr;
         if (clr)         err <= 1'b0;
         else if (expire) err <= 1'b1;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse) else $error("AST_PULSE_SINGLE"); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err) else $error("AST_ERR_STICKY"); // R6
   AST_PULSE_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> err) else $error("AST_PULSE_SETS_ERR"); // R6

endmodule

// File: rtl/rsp_gap_timer.sv
module rsp_gap_timer
   import gap_pkg::*;
#(
   parameter int unsigned SHORT_US    = 17,
   parameter int unsigned LONG_US     = 131,
   parameter int unsigned FAST_KHZ    = 24000,
   parameter int unsigned SLOW_DIV    = 2,
   parameter int unsigned LIMIT_STYLE = 0,
   parameter int unsigned CNT_W       = width_for(gap_cycles(LONG_US, FAST_KHZ))
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mst_reset,
   input  logic             msg_start,
   input  logic             tx_end,
   input  logic             rx_sync_ok,
   input  logic             gap_long_sel,
   input  logic             clk_half_sel,
   output logic             armed,
   output logic             no_rsp_pulse,
   output logic             no_rsp_err,
   output logic [CNT_W-1:0] gap_count
);

   logic             clr;
   logic             expire;
   logic [CNT_W-1:0] limit;

   assign clr = mst_reset || msg_start;

   gap_limit_sel #(
      .SHORT_US(SHORT_US), .LONG_US(LONG_US), .FAST_KHZ(FAST_KHZ),
      .SLOW_DIV(SLOW_DIV), .LIMIT_STYLE(LIMIT_STYLE), .CNT_W(CNT_W)
   ) u_limit (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(tx_end),
      .long_sel(gap_long_sel), .half_sel(clk_half_sel), .limit(limit)
   );

   gap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .arm(tx_end), .sync(rx_sync_ok),
      .limit(limit), .armed(armed), .cnt(gap_count), .expire(expire)
   );

   gap_err_flag u_err (
      .clk(clk), .rst_n(rst_n), .clr(clr), .expire(expire),
      .pulse(no_rsp_pulse), .err(no_rsp_err)
   );

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      mst_reset |=> (!armed && !no_rsp_err && gap_count == '0)) else $error("AST_CLEAR_ALL"); // R7
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start |=> (!armed && !no_rsp_err && !no_rsp_pulse)) else $error("AST_START_CLEARS"); // R8
   AST_PULSE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(no_rsp_pulse) |-> (!armed && gap_count == limit)) else $error("AST_PULSE_AT_LIMIT"); // R2

endmodule

// File: tb/tb_rsp_gap_timer.sv
module tb_rsp_gap_timer;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mst_reset = 1'b0, msg_start = 1'b0, tx_end = 1'b0, rx_sync_ok = 1'b0;
   logic         gap_long_sel = 1'b0, clk_half_sel = 1'b0;
   logic         armed, no_rsp_pulse, no_rsp_err;
   logic [W-1:0] gap_count;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   rsp_gap_timer dut (
      .clk(clk), .rst_n(rst_n), .mst_reset(mst_reset), .msg_start(msg_start),
      .tx_end(tx_end), .rx_sync_ok(rx_sync_ok), .gap_long_sel(gap_long_sel),
      .clk_half_sel(clk_half_sel), .armed(armed), .no_rsp_pulse(no_rsp_pulse),
      .no_rsp_err(no_rsp_err), .gap_count(gap_count)
   );

   function automatic int exp_limit(input bit lng, input bit half);
      return (lng ? 131 : 17) * (half ? 12 : 24);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic arm(input bit lng, input bit half);
      gap_long_sel = lng; clk_half_sel = half; tx_end = 1'b1;
      @(negedge clk);
      tx_end = 1'b0;
   endtask

   task automatic pulse_in(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      check(!armed && !no_rsp_pulse && !no_rsp_err && gap_count == 0, "R1 reset",
            {armed, no_rsp_pulse, no_rsp_err}, 0);

      // Timeout in all four select combinations
      for (int c = 0; c < 4; c++) begin
         automatic bit lng  = c[1];
         automatic bit half = c[0];
         automatic int L    = exp_limit(lng, half);
         automatic string rq = lng ? (half ? "R4 long/half" : "R3 long/fast")
                                   : (half ? "R4 short/half" : "R2 short/fast");
         pulse_in(msg_start);
         arm(lng, half);
         check(armed && gap_count == 0, "R12 armed at zero", gap_count, 0);
         edges(L - 1);
         check(!no_rsp_pulse && armed && gap_count == W'(L - 1), {rq, " before limit"},
               gap_count, L - 1);
         edges(1);
         check(no_rsp_pulse && no_rsp_err && !armed, {rq, " at limit"}, no_rsp_pulse, 1);
         check(gap_count == W'(L), "R12 count at timeout", gap_count, L);
         edges(1);
         check(!no_rsp_pulse && no_rsp_err, "R6 one-cycle pulse, sticky", no_rsp_pulse, 0);
         edges(5);
         check(no_rsp_err && !no_rsp_pulse, "R6 sticky holds", no_rsp_err, 1);
      end

      // R8 msg_start clears the error
      pulse_in(msg_start);
      check(!no_rsp_err && !armed && gap_count == 0, "R8 start clears", no_rsp_err, 0);

      // R5 sync at several offsets, including the last cycle before the limit
      for (int c = 0; c < 4; c++) begin
         automatic int L = exp_limit(c[1], c[0]);
         for (int k = 0; k < 3; k++) begin
            automatic int off = (k == 0) ? 0 : (k == 1) ? L / 2 : L - 1;
            pulse_in(mst_reset);
            arm(c[1], c[0]);
            edges(off);
            pulse_in(rx_sync_ok);
            check(!armed && gap_count == W'(off), "R5 sync disarms / R12 frozen", gap_count, off);
            edges(L - off + 2);
            check(!no_rsp_err && !no_rsp_pulse && gap_count == W'(off), "R5 no error after sync",
                  no_rsp_err, 0);
         end
      end

      // R11 sync while idle
      pulse_in(mst_reset);
      pulse_in(rx_sync_ok);
      check(!armed && !no_rsp_err && gap_count == 0, "R11 idle sync ignored", armed, 0);

      // R7 master reset mid-count and after an error
      arm(1'b0, 1'b0);
      edges(100);
      pulse_in(mst_reset);
      check(!armed && gap_count == 0, "R7 reset mid-count", gap_count, 0);
      edges(450);
      check(!no_rsp_err && !no_rsp_pulse, "R7 no timeout after reset", no_rsp_err, 0);
      arm(1'b0, 1'b1);
      edges(204);
      check(no_rsp_err, "R4 half short error", no_rsp_err, 1);
      mst_reset = 1'b1; tx_end = 1'b1;
      @(negedge clk);
      mst_reset = 1'b0; tx_end = 1'b0;
      check(!no_rsp_err && !armed, "R7 reset wins over arm", armed, 0);

      // R9 selects changed while armed have no effect
      arm(1'b0, 1'b0);
      gap_long_sel = 1'b1; clk_half_sel = 1'b1;
      edges(407);
      check(!no_rsp_pulse && armed, "R9 before limit", no_rsp_pulse, 0);
      edges(1);
      check(no_rsp_pulse, "R9 captured limit 408", no_rsp_pulse, 1);

      // R10 re-arm restarts the count
      pulse_in(msg_start);
      arm(1'b0, 1'b0);
      edges(300);
      arm(1'b0, 1'b0);
      check(armed && gap_count == 0, "R10 restart zero", gap_count, 0);
      edges(407);
      check(!no_rsp_pulse && gap_count == W'(407), "R10 not early", gap_count, 407);
      edges(1);
      check(no_rsp_pulse, "R10 fires at 408 from restart", no_rsp_pulse, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule